// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags and the interrupt-enable mask of a serial bus controller. The transfer engine sets flags with one-cycle pulses. The block combines the flags with the mask to drive a level interrupt, and with a small DMA configuration to drive a receive and a transmit DMA request. Software reaches four registers through a select code and read/write strobes: the enable mask, the flag register, the DMA configuration and a vector register. A read of the vector register names the lowest pending enabled source and acknowledges it in the same access.

A parameter selects one of two register revisions. On the newer revision the enable mask is six bits wide, and software may clear some flags by writing ones. On the older revision the mask is five bits wide, the flag register is read-only, and flags are acknowledged only through the vector register. Every output is combinational from registered state and the current access, so read data is valid in the cycle of the strobe, and side effects land at the next clock edge.

Each cycle the access decoder puts the strobes into one access kind: ACC_NONE (idle, or a write to the vector register), ACC_WR_IE (mask write), ACC_WR_STAT (flag write), ACC_WR_BUF (DMA configuration write), ACC_RD_VEC (vector read with acknowledge) and ACC_RD_OTHER (plain read). The kind is set again every cycle. A write takes precedence over a read in the same cycle. No access kind holds across cycles.

Top module: `isv_irq_unit`

## Requirements
- R1: `irq` is high exactly when at least one flag is set whose enable-mask bit is also set. Flags without an enable bit never raise it.
- R2: The flag register stores only bits 0-5, 10, 11 and 15 (bit 1 NACK, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 10 transmit underflow, bit 11 receive overrun, bit 15 single byte). A `set_flags` pulse sets those bits and drops all other bits. A flag read (select 1) returns the stored flags, with the live `bus_busy` input in bit 12.
- R3: A vector read (select 3) returns the index plus one of the lowest set bit of (flags AND mask) and clears that flag at the next edge, leaving all other flags unchanged. It returns 0 and clears nothing when nothing is pending.
- R4: With NEW_REV=1, a flag write clears the flags selected by (write data AND 0x0027), so receive ready and transmit ready survive any write. With NEW_REV=0, flag writes have no effect.
- R5: A DMA configuration write (select 2) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), and reads back the same way. A one in bit 15 clears mask bit 3, and a one in bit 7 clears mask bit 4.
- R6: `rx_dma_req` equals flag bit 3 while receive DMA is enabled, and `tx_dma_req` equals flag bit 4 while transmit DMA is enabled. Each request is low while its direction is disabled.
- R7: A mask write (select 0) keeps write-data bits [5:0] when NEW_REV=1 and bits [4:0] when NEW_REV=0. A mask read returns the stored mask, with the upper bits zero.
- R8: A synchronous reset clears the flags, the mask and the DMA configuration.
- R9: When a `set_flags` pulse and a clear (vector acknowledge or flag write) hit the same flag in one cycle, the flag ends up set.
- R10: A write to the vector register changes no state. `rd_data` is 0 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_flags | input | 16 | One-cycle flag-set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy level, shown in flag read bit 12 |
| reg_sel | input | 2 | Register select: 0 mask, 1 flags, 2 DMA config, 3 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds two instances side by side from the same stimulus: `dut` with NEW_REV=1 and `dut_old` with NEW_REV=0. Driving both with the same stimulus shows the revision differences directly. The same mask write keeps six bits in one instance and five in the other. The same flag write clears bits in one and nothing in the other. Because the two masks differ, the same vector read lands on different sources. Both revisions go through the collision between a set pulse and an acknowledge, and through the DMA enables clearing the mask bits.

// File: rtl/isv_pkg.sv
package isv_pkg;

    localparam int DW = 16;

    // register select codes seen on reg_sel
    typedef enum logic [1:0] {
        SEL_IE   = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BUF  = 2'd2,
        SEL_VEC  = 2'd3
    } sel_e;

    // per-cycle access kind produced by the decoder
    typedef enum logic [2:0] {
        ACC_NONE     = 3'd0,
        ACC_WR_IE    = 3'd1,
        ACC_WR_STAT  = 3'd2,
        ACC_WR_BUF   = 3'd3,
        ACC_RD_VEC   = 3'd4,
        ACC_RD_OTHER = 3'd5
    } acc_e;

    localparam logic [DW-1:0] STAT_IMPL = 16'h8C3F;
    localparam logic [DW-1:0] SW_CLR    = 16'h0027;
    localparam int BUSY_BIT  = 12;
    localparam int RXRDY_BIT = 3;
    localparam int TXRDY_BIT = 4;
    localparam int RXDMA_BIT = 15;
    localparam int TXDMA_BIT = 7;

endpackage

// File: rtl/isv_decode.sv
module isv_decode
    import isv_pkg::*;
(
    input  logic reg_wr,
    input  logic reg_rd,
    input  sel_e sel,
    output acc_e acc
);

    always_comb begin
        acc = ACC_NONE;
        if (reg_wr) begin
            unique case (sel)
                SEL_IE:   acc = ACC_WR_IE;
                SEL_STAT: acc = ACC_WR_STAT;
                SEL_BUF:  acc = ACC_WR_BUF;
                SEL_VEC:  acc = ACC_NONE;   // vector register is read-only
            endcase
        end else if (reg_rd) begin
            acc = (sel == SEL_VEC) ? ACC_RD_VEC : ACC_RD_OTHER;
        end
    end

endmodule

// File: rtl/isv_status.sv
module isv_status
    import isv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_e          acc,
    input  logic [DW-1:0] set_flags,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] vec_clr,
    output logic [DW-1:0] stat
);

    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;
    logic [DW-1:0] stat_q;

    assign set_bits = set_flags & STAT_IMPL;

    always_comb begin
        clr_bits = '0;
        unique case (acc)
            ACC_WR_STAT: clr_bits = NEW_REV ? (wr_data & SW_CLR) : '0;
            ACC_RD_VEC:  clr_bits = vec_clr;
            default:     clr_bits = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_bits) | set_bits;
    end

    assign stat = stat_q;

    assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~STAT_IMPL) == '0);

    assert_ready_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WR_STAT && stat_q[RXRDY_BIT] && stat_q[TXRDY_BIT])
        |=> (stat_q[RXRDY_BIT] && stat_q[TXRDY_BIT]));

    assert_old_ro_R4: assert property (@(posedge clk) disable iff (rst)
        (!NEW_REV && acc == ACC_WR_STAT && set_flags == '0) |=> $stable(stat_q));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((stat_q & $past(set_bits)) == $past(set_bits)));

endmodule

// File: rtl/isv_cfg.sv
module isv_cfg
    import isv_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              rx_en_wdata,
    input  logic              tx_en_wdata,
    output logic [MASK_W-1:0] mask,
    output logic              rx_dma_en,
    output logic              tx_dma_en
);

    logic [MASK_W-1:0] mask_q, mask_n;
    logic              rx_q, tx_q;
    logic [MASK_W-1:0] dma_strip;

    // mask bits taken over by DMA enables
    always_comb begin
        dma_strip = '0;
        dma_strip[RXRDY_BIT] = rx_en_wdata;
        dma_strip[TXRDY_BIT] = tx_en_wdata;
    end

    always_comb begin
        mask_n = mask_q;
        unique case (acc)
            ACC_WR_IE:  mask_n = mask_wdata;
            ACC_WR_BUF: mask_n = mask_q & ~dma_strip;
            default:    mask_n = mask_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            rx_q   <= 1'b0;
            tx_q   <= 1'b0;
        end else begin
            mask_q <= mask_n;
            if (acc == ACC_WR_BUF) begin
                rx_q <= rx_en_wdata;
                tx_q <= tx_en_wdata;
            end
        end
    end

    assign mask      = mask_q;
    assign rx_dma_en = rx_q;
    assign tx_dma_en = tx_q;

    assert_rxdma_strips_ie_R5: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WR_BUF && rx_en_wdata) |=> (!mask_q[RXRDY_BIT] && rx_q));

    assert_txdma_strips_ie_R5: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WR_BUF && tx_en_wdata) |=> (!mask_q[TXRDY_BIT] && tx_q));

endmodule

// File: rtl/isv_vector.sv
module isv_vector
    import isv_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] pend,
    output logic              found,
    output logic [DW-1:0]     vec_val,
    output logic [DW-1:0]     vec_clr
);

    localparam int IDX_W = $clog2(MASK_W);

    logic [IDX_W-1:0] idx;

    // lowest set bit wins: scan from the top so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        vec_val = '0;
        vec_clr = '0;
        if (found) begin
            vec_val = {{(DW-IDX_W){1'b0}}, idx} + 16'd1;
            vec_clr[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/isv_irq_unit.sv
module isv_irq_unit
    import isv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] set_flags,
    input  logic        bus_busy,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        irq,
    output logic        rx_dma_req,
    output logic        tx_dma_req
);

    localparam int MASK_W = NEW_REV ? 6 : 5;

    sel_e              sel;
    acc_e              acc;
    logic [DW-1:0]     stat;
    logic [MASK_W-1:0] mask;
    logic              rx_dma_en, tx_dma_en;
    logic [MASK_W-1:0] pend;
    logic              vec_found;
    logic [DW-1:0]     vec_val, vec_clr;
    logic [DW-1:0]     mask_word, dma_word;

    assign sel = sel_e'(reg_sel);

    isv_decode u_dec (
        .reg_wr (reg_wr),
        .reg_rd (reg_rd),
        .sel    (sel),
        .acc    (acc)
    );

    isv_status #(.NEW_REV(NEW_REV)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .set_flags (set_flags),
        .wr_data   (wr_data),
        .vec_clr   (vec_clr),
        .stat      (stat)
    );

    isv_cfg #(.MASK_W(MASK_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .mask_wdata  (wr_data[MASK_W-1:0]),
        .rx_en_wdata (wr_data[RXDMA_BIT]),
        .tx_en_wdata (wr_data[TXDMA_BIT]),
        .mask        (mask),
        .rx_dma_en   (rx_dma_en),
        .tx_dma_en   (tx_dma_en)
    );

    assign pend = stat[MASK_W-1:0] & mask;

    isv_vector #(.MASK_W(MASK_W)) u_vec (
        .pend    (pend),
        .found   (vec_found),
        .vec_val (vec_val),
        .vec_clr (vec_clr)
    );

    always_comb begin
        mask_word = '0;
        mask_word[MASK_W-1:0] = mask;
        dma_word = '0;
        dma_word[RXDMA_BIT] = rx_dma_en;
        dma_word[TXDMA_BIT] = tx_dma_en;
    end

    always_comb begin
        rd_data = '0;
        if (acc == ACC_RD_VEC) begin
            rd_data = vec_val;
        end else if (acc == ACC_RD_OTHER) begin
            unique case (sel)
                SEL_IE:   rd_data = mask_word;
                SEL_STAT: rd_data = stat | (16'(bus_busy) << BUSY_BIT);
                SEL_BUF:  rd_data = dma_word;
                default:  rd_data = '0;
            endcase
        end
    end

    assign irq        = |pend;
    assign rx_dma_req = rx_dma_en & stat[RXRDY_BIT];
    assign tx_dma_req = tx_dma_en & stat[TXRDY_BIT];

    assert_irq_has_vector_R1: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD_VEC && irq) |-> (rd_data != '0));

    assert_vec_acks_R3: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD_VEC && vec_found && (set_flags & vec_clr) == '0)
        |=> ((stat & $past(vec_clr)) == '0));

    assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!reg_rd) |-> (rd_data == '0));

endmodule

// File: tb/tb_isv_irq_unit.sv
module tb_isv_irq_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst;
    logic [15:0] set_flags, wr_data;
    logic [1:0]  reg_sel;
    logic        reg_wr, reg_rd, bus_busy;
    logic [15:0] n_rd, o_rd;
    logic        n_irq, n_rx, n_tx, o_irq, o_rx, o_tx;

    isv_irq_unit #(.NEW_REV(1'b1)) dut (
        .clk(clk), .rst(rst), .set_flags(set_flags), .bus_busy(bus_busy),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data),
        .rd_data(n_rd), .irq(n_irq), .rx_dma_req(n_rx), .tx_dma_req(n_tx));

    isv_irq_unit #(.NEW_REV(1'b0)) dut_old (
        .clk(clk), .rst(rst), .set_flags(set_flags), .bus_busy(bus_busy),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data),
        .rd_data(o_rd), .irq(o_irq), .rx_dma_req(o_rx), .tx_dma_req(o_tx));

    localparam logic [1:0] S_IE = 2'd0, S_ST = 2'd1, S_BUF = 2'd2, S_VEC = 2'd3;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [15:0] q_new[$];
    logic [15:0] q_old[$];
    string       q_tag[$];

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 2'd0;
        wr_data = '0; set_flags = '0;
    endtask

    // driver: one access, expected read data pushed to the scoreboard
    task automatic access(bit wr, bit rd, logic [1:0] sel, logic [15:0] data,
                          logic [15:0] setf, logic [15:0] exp_n,
                          logic [15:0] exp_o, string tag);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; wr_data = data; set_flags = setf;
        if (rd) begin
            q_new.push_back(exp_n);
            q_old.push_back(exp_o);
            q_tag.push_back(tag);
        end
        @(negedge clk);
        idle();
    endtask

    task automatic rd(logic [1:0] sel, logic [15:0] en, logic [15:0] eo, string tag);
        access(1'b0, 1'b1, sel, 16'h0, 16'h0, en, eo, tag);
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] data);
        access(1'b1, 1'b0, sel, data, 16'h0, 16'h0, 16'h0, "");
    endtask

    task automatic pulse(logic [15:0] setf);
        access(1'b0, 1'b0, 2'd0, 16'h0, setf, 16'h0, 16'h0, "");
    endtask

    // line check point: inputs idle, away from the edge
    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    // monitor: pops expected read data while a read strobe is up
    always @(negedge clk) begin
        #2;
        if (reg_rd === 1'b1 && q_new.size() > 0) begin
            automatic logic [15:0] en = q_new.pop_front();
            automatic logic [15:0] eo = q_old.pop_front();
            automatic string       tg = q_tag.pop_front();
            check({tg, " rev1"}, n_rd, en);
            check({tg, " rev0"}, o_rd, eo);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        bus_busy = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        rd(S_ST,  16'h0000, 16'h0000, "R8 flags after reset");
        rd(S_IE,  16'h0000, 16'h0000, "R8 mask after reset");
        rd(S_BUF, 16'h0000, 16'h0000, "R8 dma after reset");
        settle();
        check("R8 irq after reset", {15'd0, n_irq}, 16'h0);

        // R2 busy bit is live
        bus_busy = 1'b1;
        rd(S_ST, 16'h1000, 16'h1000, "R2 busy in bit 12");
        bus_busy = 1'b0;

        // R2 only implemented flags stick
        pulse(16'h8E3F);
        rd(S_ST, 16'h8C3F, 16'h8C3F, "R2 implemented flags");
        settle();
        check("R1 no irq with empty mask rev1", {15'd0, n_irq}, 16'h0);
        check("R1 no irq with empty mask rev0", {15'd0, o_irq}, 16'h0);

        // R7 mask width per revision
        wr(S_IE, 16'hFFFF);
        rd(S_IE, 16'h003F, 16'h001F, "R7 mask width");
        settle();
        check("R1 irq rev1", {15'd0, n_irq}, 16'h1);
        check("R1 irq rev0", {15'd0, o_irq}, 16'h1);

        // R3 vector order and acknowledge
        rd(S_VEC, 16'd1, 16'd1, "R3 first vector");
        rd(S_VEC, 16'd2, 16'd2, "R3 second vector");
        rd(S_ST, 16'h8C3C, 16'h8C3C, "R3 acked flags gone");

        // R4 software clear only on rev1, and only bits of 0x27
        wr(S_ST, 16'hFFFF);
        rd(S_ST, 16'h8C18, 16'h8C3C, "R4 flag write");

        // R3 mask differences pick different sources
        rd(S_VEC, 16'd4, 16'd3, "R3 vector after flag write");
        rd(S_ST, 16'h8C10, 16'h8C38, "R3 only acked flag cleared");

        // R5 DMA enables strip mask bits
        wr(S_BUF, 16'hFFFF);
        rd(S_BUF, 16'h8080, 16'h8080, "R5 dma config bits");
        rd(S_IE, 16'h0027, 16'h0007, "R5 mask bits 3 and 4 cleared");
        settle();
        check("R6 rx req rev1", {15'd0, n_rx}, 16'h0);
        check("R6 tx req rev1", {15'd0, n_tx}, 16'h1);
        check("R6 rx req rev0", {15'd0, o_rx}, 16'h1);
        check("R6 tx req rev0", {15'd0, o_tx}, 16'h1);
        check("R1 masked flags no irq rev1", {15'd0, n_irq}, 16'h0);
        check("R1 masked flags no irq rev0", {15'd0, o_irq}, 16'h0);

        wr(S_BUF, 16'h0000);
        settle();
        check("R6 rx req off rev0", {15'd0, o_rx}, 16'h0);
        check("R6 tx req off rev1", {15'd0, n_tx}, 16'h0);

        // R9 set pulse beats acknowledge
        wr(S_IE, 16'h0001);
        pulse(16'h0001);
        access(1'b0, 1'b1, S_VEC, 16'h0, 16'h0001, 16'd1, 16'd1, "R9 vector during set");
        rd(S_ST, 16'h8C11, 16'h8C39, "R9 flag survives");
        settle();
        check("R9 irq still up rev1", {15'd0, n_irq}, 16'h1);
        check("R9 irq still up rev0", {15'd0, o_irq}, 16'h1);
        rd(S_VEC, 16'd1, 16'd1, "R3 plain acknowledge");
        rd(S_ST, 16'h8C10, 16'h8C38, "R3 flag cleared");

        // R10 vector write ignored, idle read data zero
        wr(S_VEC, 16'hFFFF);
        rd(S_ST, 16'h8C10, 16'h8C38, "R10 flags after vector write");
        rd(S_IE, 16'h0001, 16'h0001, "R10 mask after vector write");
        settle();
        check("R10 idle rd_data rev1", n_rd, 16'h0);
        check("R10 idle rd_data rev0", o_rd, 16'h0);

        // R3 nothing pending
        rd(S_VEC, 16'd0, 16'd0, "R3 empty vector");

        // R8 reset after activity
        wr(S_BUF, 16'h8080);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(S_ST,  16'h0000, 16'h0000, "R8 flags after second reset");
        rd(S_IE,  16'h0000, 16'h0000, "R8 mask after second reset");
        rd(S_BUF, 16'h0000, 16'h0000, "R8 dma after second reset");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule